// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt controller of a small 16-bit processor model. Whenever the core reports that an instruction has finished, the block looks at the pending interrupt causes in a fixed order. These causes are an internal fault, a latched non-maskable request, a maskable request gated by the interrupt-enable flag, and the single-step trap gated by the trap flag. It works out an 8-bit type for the winning cause. Built-in types are supplied directly. For the maskable request, the type is read from the requesting device over two acknowledge pulses. The type times four addresses a four-byte entry in the vector table.

Entry saves the flags word, CS and IP on the stack through a byte-wide memory port that has a ready handshake, and clears the enable and trap flags. It then reads the new IP and CS from the table. A trap flag saved at entry, or a non-maskable request that arrives during the sequence, causes a second entry at once, before any handler instruction runs. The block also holds the processor in a halted state until an external request arrives. On a return request it unwinds one stack frame. The block owns the architectural FLAGS, CS, IP and SP words. Because the stack segment is zero, stack addresses are SP zero-extended.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, cs_o=0xFFFF, ip_o=0, flags_o=0, sp_o=SP_RESET, and busy_o, halted_o, inta_o and mem_req_o are all low.
- R2: Causes are evaluated only in a cycle with boundary_i high while idle, or at any time while halted. Fault beats NMI, NMI beats INTR (only when flags bit 9, IF, is set), and INTR beats the step trap (only when flags bit 8, TF, is set). A losing cause is not serviced by that entry.
- R3: A fault uses fault_type_i as its type, NMI uses type 2 and the step trap uses type 1. The table entry is at byte address type*4, so type 0x36 maps to 0x0D8. The new IP is read from entry bytes +0 (low) and +1 (high), and the new CS from bytes +2 (low) and +3 (high).
- R4: Entry pushes three words: FLAGS, then CS, then IP. Each push first lowers SP by 2 and writes the low byte at the lower address. SP ends 6 lower. The pushed FLAGS word is the value before IF and TF are cleared, and the pushed IP is the ip_next_i given with the boundary.
- R5: Entry clears IF (bit 9) and TF (bit 8) before any push and leaves every other flag bit unchanged.
- R6: For INTR the block raises inta_o for two pulses of exactly 2 clocks each, with one low clock between them. The type byte is taken from mem_rdata_i in the last clock of the second pulse.
- R7: NMI is taken on a rising edge of nmi_i and held pending until serviced. A level held high does not start a second entry. An NMI that becomes pending during an entry is serviced right after that entry, without a boundary.
- R8: TF is saved at each entry, except when the entry is itself the step trap. If the saved bit is set and no NMI is pending, a type 1 entry follows at once.
- R9: halt_i at a boundary with no cause pending enters the halted state, in which the memory port is idle. The block leaves this state only on reset, a pending NMI or an enabled INTR. Faults, boundaries and TF have no effect while halted.
- R10: If iret_i is high at a boundary with no cause pending, the block reads IP from SP, CS from SP+2 and FLAGS from SP+4, low byte first. SP rises by 6, and IF and TF take their values from the popped word.
- R11: Every byte access holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o steady until a cycle with mem_rdy_i high. Wait states change no result.
- R12: flags_we_i loads flags_wdata_i into FLAGS while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Current instruction has completed |
| ip_next_i | input | 16 | Address of the next instruction, sampled with boundary_i |
| fault_i | input | 1 | Internal fault or software interrupt at this boundary |
| fault_type_i | input | 8 | Type number of the internal fault |
| iret_i | input | 1 | Return-from-interrupt request at this boundary |
| halt_i | input | 1 | Halt request at this boundary |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sampled |
| flags_we_i | input | 1 | Write strobe for FLAGS |
| flags_wdata_i | input | 16 | New FLAGS value |
| mem_req_o | output | 1 | Byte access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, or type byte during acknowledge |
| mem_rdy_i | input | 1 | Access completes this cycle |
| inta_o | output | 1 | Interrupt acknowledge pulse |
| busy_o | output | 1 | Acknowledge, entry or return sequence in progress |
| halted_o | output | 1 | Halted state |
| flags_o | output | 16 | FLAGS word |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |

## Verification
The bench builds the block with its default parameters: ADDR_W=20, SP_RESET=0x0800 and CS_RESET=0xFFFF. This places the stack at 0x0800, just above the vector table at 0x000–0x3FF. A 4 KiB bench memory then holds every pushed frame and every table entry, so chained double entries and their unwinding by two returns can be checked byte by byte. The ready line can be switched to stall every other cycle, so an entry and a return run again with wait states and must give the same bytes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam logic [7:0] TYPE_STEP = 8'h01;
  localparam logic [7:0] TYPE_NMI  = 8'h02;

  typedef enum logic [2:0] {ST_IDLE, ST_HALT, ST_ACK, ST_ENTRY, ST_POP} seq_state_e;
  typedef enum logic [1:0] {SRC_FAULT, SRC_NMI, SRC_INTR, SRC_STEP} src_e;
endpackage

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
(
  input  logic       fault_i,
  input  logic [7:0] fault_type_i,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       step_i,
  output logic       take_o,
  output src_e       src_o,
  output logic [7:0] type_o
);
  always_comb begin
    take_o = fault_i | nmi_i | intr_i | step_i;
    src_o  = SRC_STEP;
    type_o = TYPE_STEP;
    if (fault_i) begin
      src_o  = SRC_FAULT;
      type_o = fault_type_i;
    end else if (nmi_i) begin
      src_o  = SRC_NMI;
      type_o = TYPE_NMI;
    end else if (intr_i) begin
      src_o  = SRC_INTR;
      type_o = 8'h00;  // fetched by acknowledge
    end
  end
endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              pop_i,
  input  logic [3:0]        step_i,
  input  logic [15:0]       sp_i,
  input  logic [7:0]        type_i,
  input  logic [15:0]       flags_i,
  input  logic [15:0]       cs_i,
  input  logic [15:0]       ip_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              we_o,
  output logic [2:0]        idx_o
);
  localparam int STK_PAD = ADDR_W - 16;
  localparam int TBL_PAD = ADDR_W - 10;

  logic [15:0] push_off, stk_addr, word;
  logic [3:0]  rd_rel;

  always_comb begin
    // entry steps 0..5 write three words downward, 6..9 read the table entry
    push_off = {13'd0, step_i[2:1], 1'b0} + 16'd2 - {15'd0, step_i[0]};
    rd_rel   = step_i - 4'd6;
    we_o     = !pop_i && (step_i < 4'd6);
    stk_addr = pop_i ? sp_i + {12'd0, step_i} : sp_i - push_off;
    case (step_i[2:1])
      2'd0:    word = flags_i;
      2'd1:    word = cs_i;
      default: word = ip_i;
    endcase
    wdata_o = step_i[0] ? word[15:8] : word[7:0];
    if (!pop_i && !we_o) begin
      addr_o = {{TBL_PAD{1'b0}}, type_i, rd_rel[1:0]};
      idx_o  = {1'b0, rd_rel[1:0]};
    end else begin
      addr_o = {{STK_PAD{1'b0}}, stk_addr};
      idx_o  = step_i[2:0];
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter logic [15:0] SP_RESET = 16'h0800,
  parameter logic [15:0] CS_RESET = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [15:0]       ip_next_i,
  input  logic              fault_i,
  input  logic [7:0]        fault_type_i,
  input  logic              iret_i,
  input  logic              halt_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              flags_we_i,
  input  logic [15:0]       flags_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              inta_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic [15:0]       flags_o,
  output logic [15:0]       cs_o,
  output logic [15:0]       ip_o,
  output logic [15:0]       sp_o
);
  localparam int         STEP_W     = 4;
  localparam logic [3:0] ACK_GAP    = 4'd2;
  localparam logic [3:0] ACK_LAST   = 4'd4;
  localparam logic [3:0] PUSH_LAST  = 4'd5;
  localparam logic [3:0] ENTRY_LAST = 4'd9;
  localparam logic [3:0] POP_LAST   = 4'd5;
  localparam logic [15:0] FRAME     = 16'd6;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        type_q;
  logic [15:0]       snap_q, flags_q, cs_q, ip_q, sp_q;
  logic [47:0]       buf_q;
  logic              temp_q, nmi_q, nmi_pend_q;

  logic       at_bnd, in_halt, last_rd, take;
  logic       p_fault, p_nmi, p_intr, p_step;
  src_e       src;
  logic [7:0] src_type;
  logic [2:0] idx;
  logic       gen_we;

  assign at_bnd  = (state_q == ST_IDLE) && boundary_i;
  assign in_halt = (state_q == ST_HALT);
  assign last_rd = (state_q == ST_ENTRY) && (step_q == ENTRY_LAST) && mem_rdy_i;

  assign p_fault = at_bnd && fault_i;
  assign p_nmi   = nmi_pend_q && (at_bnd || in_halt || last_rd);
  assign p_intr  = intr_i && flags_q[IF_BIT] && (at_bnd || in_halt);
  assign p_step  = at_bnd ? flags_q[TF_BIT] : (last_rd && temp_q);

  irq_prio u_prio (
    .fault_i      (p_fault),
    .fault_type_i (fault_type_i),
    .nmi_i        (p_nmi),
    .intr_i       (p_intr),
    .step_i       (p_step),
    .take_o       (take),
    .src_o        (src),
    .type_o       (src_type)
  );

  irq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .pop_i   (state_q == ST_POP),
    .step_i  (step_q),
    .sp_i    (sp_q),
    .type_i  (type_q),
    .flags_i (snap_q),
    .cs_i    (cs_q),
    .ip_i    (ip_q),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .we_o    (gen_we),
    .idx_o   (idx)
  );

  assign mem_req_o = (state_q == ST_ENTRY) || (state_q == ST_POP);
  assign mem_we_o  = (state_q == ST_ENTRY) && gen_we;
  assign inta_o    = (state_q == ST_ACK) && (step_q != ACK_GAP);
  assign busy_o    = (state_q == ST_ACK) || mem_req_o;
  assign halted_o  = in_halt;
  assign flags_o   = flags_q;
  assign cs_o      = cs_q;
  assign ip_o      = ip_q;
  assign sp_o      = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      type_q     <= '0;
      snap_q     <= '0;
      flags_q    <= '0;
      cs_q       <= CS_RESET;
      ip_q       <= '0;
      sp_q       <= SP_RESET;
      buf_q      <= '0;
      temp_q     <= 1'b0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      case (state_q)
        ST_IDLE: begin
          if (flags_we_i && !take) flags_q <= flags_wdata_i;
          if (boundary_i) begin
            ip_q <= ip_next_i;
            if (iret_i) begin
              state_q <= ST_POP;
              step_q  <= '0;
            end else if (halt_i) begin
              state_q <= ST_HALT;
            end
          end
        end
        ST_ACK: begin
          step_q <= step_q + 1'b1;
          if (step_q == ACK_LAST) begin
            type_q  <= mem_rdata_i;
            state_q <= ST_ENTRY;
            step_q  <= '0;
          end
        end
        ST_ENTRY: begin
          if (mem_rdy_i) begin
            step_q <= step_q + 1'b1;
            if (step_q == PUSH_LAST) sp_q <= sp_q - FRAME;
            if (!gen_we) buf_q[{idx, 3'b000} +: 8] <= mem_rdata_i;
            if (step_q == ENTRY_LAST) begin
              ip_q    <= buf_q[15:0];
              cs_q    <= {mem_rdata_i, buf_q[23:16]};
              state_q <= ST_IDLE;
            end
          end
        end
        ST_POP: begin
          if (mem_rdy_i) begin
            step_q <= step_q + 1'b1;
            buf_q[{idx, 3'b000} +: 8] <= mem_rdata_i;
            if (step_q == POP_LAST) begin
              ip_q    <= buf_q[15:0];
              cs_q    <= buf_q[31:16];
              flags_q <= {mem_rdata_i, buf_q[39:32]};
              sp_q    <= sp_q + FRAME;
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
      if (take) begin
        snap_q          <= flags_q;
        flags_q[IF_BIT] <= 1'b0;
        flags_q[TF_BIT] <= 1'b0;
        temp_q          <= flags_q[TF_BIT] && (src != SRC_STEP);
        type_q          <= src_type;
        step_q          <= '0;
        state_q         <= (src == SRC_INTR) ? ST_ACK : ST_ENTRY;
        if (src == SRC_NMI) nmi_pend_q <= 1'b0;
      end
      if (nmi_i && !nmi_q) nmi_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_rdy_i,
  input logic              inta_o,
  input logic              busy_o,
  input logic              halted_o,
  input logic [15:0]       flags_o,
  input logic [15:0]       sp_o
);
  a_r4_push_below_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_addr_o[15:0] < sp_o);

  a_r5_flags_clear_in_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !flags_o[9] && !flags_o[8]);

  a_r6_inta_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inta_o) |=> inta_o ##1 !inta_o);

  a_r6_inta_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> busy_o && !mem_req_o);

  a_r9_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o && !inta_o && !busy_o);

  a_r11_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i),
  .inta_o      (inta_o),
  .busy_o      (busy_o),
  .halted_o    (halted_o),
  .flags_o     (flags_o),
  .sp_o        (sp_o)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        boundary, fault, iret, halt, nmi, intr, flags_we;
  logic [15:0] ip_next, flags_wdata;
  logic [7:0]  fault_type, ack_byte;
  logic        mem_req, mem_we, mem_rdy, inta, busy, halted;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] flags, cs, ip, sp;

  logic [7:0]  mem [0:4095];
  logic        tb_we;
  logic [11:0] tb_addr;
  logic [7:0]  tb_data;
  logic        stall_en, stall_q;
  int          inta_cyc, inta_rise;
  logic        inta_prev;
  int          n_chk, n_fail;

  irq_entry_seq u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .ip_next_i(ip_next),
    .fault_i(fault), .fault_type_i(fault_type), .iret_i(iret), .halt_i(halt),
    .nmi_i(nmi), .intr_i(intr), .flags_we_i(flags_we), .flags_wdata_i(flags_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .inta_o(inta), .busy_o(busy), .halted_o(halted), .flags_o(flags),
    .cs_o(cs), .ip_o(ip), .sp_o(sp)
  );

  assign mem_rdy   = mem_req & ~stall_q;
  assign mem_rdata = inta ? ack_byte : mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_req && mem_we && mem_rdy) mem[mem_addr[11:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    stall_q <= stall_en ? ~stall_q : 1'b0;
    if (inta) inta_cyc = inta_cyc + 1;
    if (inta && !inta_prev) inta_rise = inta_rise + 1;
    inta_prev = inta;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input int a);
    return {mem[a+1], mem[a]};
  endfunction

  task automatic poke16(input int a, input logic [15:0] v);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 12'(a + i); tb_data = i ? v[15:8] : v[7:0];
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_vec(input int t, input logic [15:0] vip, input logic [15:0] vcs);
    poke16(t * 4, vip);
    poke16(t * 4 + 2, vcs);
  endtask

  task automatic write_flags(input logic [15:0] v);
    @(negedge clk);
    flags_we = 1'b1; flags_wdata = v;
    @(negedge clk);
    flags_we = 1'b0;
  endtask

  task automatic bnd(input logic f, input logic [7:0] ft, input logic h, input logic r,
                     input logic [15:0] ipn);
    @(negedge clk);
    boundary = 1'b1; fault = f; fault_type = ft; halt = h; iret = r; ip_next = ipn;
    @(negedge clk);
    boundary = 1'b0; fault = 1'b0; halt = 1'b0; iret = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 500 && busy; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cs", cs, 16'hFFFF);
    chk("R1", "ip", ip, 16'h0000);
    chk("R1", "flags", flags, 16'h0000);
    chk("R1", "sp", sp, 16'h0800);
    chk("R1", "busy/halt/inta/req", {busy, halted, inta, mem_req}, 4'b0000);
    write_flags(16'h02C5);
    chk("R12", "flags after write", flags, 16'h02C5);
  endtask

  task automatic t_fault_entry();
    set_vec(0, 16'h0100, 16'h2000);
    bnd(1'b1, 8'h00, 1'b0, 1'b0, 16'h1234);
    wait_idle();
    chk("R4", "pushed flags", rd16(16'h07FE), 16'h02C5);
    chk("R4", "pushed cs", rd16(16'h07FC), 16'hFFFF);
    chk("R4", "pushed ip", rd16(16'h07FA), 16'h1234);
    chk("R4", "sp after entry", sp, 16'h07FA);
    chk("R3", "new cs:ip", {cs, ip}, {16'h2000, 16'h0100});
    chk("R5", "flags after entry", flags, 16'h00C5);
  endtask

  task automatic t_iret(input logic [15:0] e_ip, input logic [15:0] e_cs,
                        input logic [15:0] e_fl, input logic [15:0] e_sp);
    bnd(1'b0, 8'h00, 1'b0, 1'b1, 16'h9999);
    wait_idle();
    chk("R10", "popped ip", ip, e_ip);
    chk("R10", "popped cs", cs, e_cs);
    chk("R10", "popped flags", flags, e_fl);
    chk("R10", "sp after pop", sp, e_sp);
  endtask

  task automatic t_int36();
    set_vec(8'h36, 16'h4455, 16'h6677);
    chk("R3", "table bytes at 0xD8", {mem[16'hDB], mem[16'hDA], mem[16'hD9], mem[16'hD8]},
        32'h66774455);
    write_flags(16'h0200);
    bnd(1'b1, 8'h36, 1'b0, 1'b0, 16'h0010);
    wait_idle();
    chk("R3", "int 36 cs:ip", {cs, ip}, {16'h6677, 16'h4455});
    chk("R4", "int 36 pushed ip", rd16(16'h07FA), 16'h0010);
    t_iret(16'h0010, 16'hFFFF, 16'h0200, 16'h0800);
  endtask

  task automatic t_priority();
    set_vec(8'h21, 16'h1111, 16'h2222);
    set_vec(2, 16'h3333, 16'h4444);
    write_flags(16'h0200);
    inta_cyc = 0;
    @(negedge clk); nmi = 1'b1; intr = 1'b1;
    bnd(1'b1, 8'h21, 1'b0, 1'b0, 16'h0ABC);
    wait_idle();
    intr = 1'b0;
    chk("R2", "fault frame flags", rd16(16'h07FE), 16'h0200);
    chk("R7", "nmi chained cs:ip", {cs, ip}, {16'h4444, 16'h3333});
    chk("R7", "nmi frame ip = fault handler", rd16(16'h07F4), 16'h1111);
    chk("R7", "nmi frame cs", rd16(16'h07F6), 16'h2222);
    chk("R2", "intr not acknowledged", inta_cyc, 0);
    chk("R4", "sp after two frames", sp, 16'h07F4);
    // nmi still high: no second entry
    bnd(1'b0, 8'h00, 1'b0, 1'b0, 16'h5555);
    repeat (4) @(negedge clk);
    chk("R7", "held nmi level: busy", busy, 1'b0);
    chk("R7", "held nmi level: ip", ip, 16'h5555);
    nmi = 1'b0;
    t_iret(16'h1111, 16'h2222, 16'h0000, 16'h07FA);
    t_iret(16'h0ABC, 16'hFFFF, 16'h0200, 16'h0800);
  endtask

  task automatic t_intr();
    set_vec(8'h40, 16'hAAAA, 16'hBBBB);
    write_flags(16'h0000);
    intr = 1'b1; ack_byte = 8'h40; inta_cyc = 0; inta_rise = 0;
    bnd(1'b0, 8'h00, 1'b0, 1'b0, 16'h0050);
    repeat (6) @(negedge clk);
    chk("R2", "intr masked: busy", busy, 1'b0);
    chk("R2", "intr masked: no inta", inta_cyc, 0);
    chk("R2", "intr masked: ip", ip, 16'h0050);
    write_flags(16'h0200);
    bnd(1'b0, 8'h00, 1'b0, 1'b0, 16'h0060);
    wait_idle();
    intr = 1'b0;
    chk("R6", "inta high clocks", inta_cyc, 4);
    chk("R6", "inta pulses", inta_rise, 2);
    chk("R6", "intr handler cs:ip", {cs, ip}, {16'hBBBB, 16'hAAAA});
    t_iret(16'h0060, 16'hFFFF, 16'h0200, 16'h0800);
  endtask

  task automatic t_step();
    set_vec(1, 16'h0E00, 16'h0F00);
    set_vec(4, 16'h4040, 16'h5050);
    write_flags(16'h0100);
    bnd(1'b0, 8'h00, 1'b0, 1'b0, 16'h0777);
    wait_idle();
    chk("R2", "step trap cs:ip", {cs, ip}, {16'h0F00, 16'h0E00});
    chk("R8", "single frame for step trap", sp, 16'h07FA);
    chk("R4", "step frame flags", rd16(16'h07FE), 16'h0100);
    t_iret(16'h0777, 16'hFFFF, 16'h0100, 16'h0800);
    // TF=1 restored; overflow fault then saved-TF trap
    bnd(1'b1, 8'h04, 1'b0, 1'b0, 16'h0888);
    wait_idle();
    chk("R8", "chained step cs:ip", {cs, ip}, {16'h0F00, 16'h0E00});
    chk("R8", "step frame ip = type 4 handler", rd16(16'h07F4), 16'h4040);
    chk("R8", "step frame flags", rd16(16'h07F8), 16'h0000);
    chk("R8", "type 4 frame flags", rd16(16'h07FE), 16'h0100);
    t_iret(16'h4040, 16'h5050, 16'h0000, 16'h07FA);
    t_iret(16'h0888, 16'hFFFF, 16'h0100, 16'h0800);
  endtask

  task automatic t_halt();
    write_flags(16'h0100);
    write_flags(16'h0000);
    bnd(1'b0, 8'h00, 1'b1, 1'b0, 16'h0321);
    chk("R9", "halted", halted, 1'b1);
    intr = 1'b1;
    write_flags(16'h0100);
    bnd(1'b1, 8'h21, 1'b0, 1'b0, 16'h0444);
    repeat (6) @(negedge clk);
    chk("R9", "still halted", halted, 1'b1);
    chk("R9", "no sequence while halted", {busy, sp}, {1'b0, 16'h0800});
    chk("R9", "ip unchanged while halted", ip, 16'h0321);
    @(negedge clk); nmi = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "nmi leaves halt", halted, 1'b0);
    wait_idle();
    nmi = 1'b0; intr = 1'b0;
    chk("R9", "nmi handler after halt", {cs, ip}, {16'h4444, 16'h3333});
    chk("R4", "halt frame ip", rd16(16'h07FA), 16'h0321);
    t_iret(16'h0321, 16'hFFFF, 16'h0000, 16'h0800);
  endtask

  task automatic t_wait_states();
    stall_en = 1'b1;
    write_flags(16'h0201);
    bnd(1'b1, 8'h36, 1'b0, 1'b0, 16'h0BEE);
    wait_idle();
    chk("R11", "stalled cs:ip", {cs, ip}, {16'h6677, 16'h4455});
    chk("R11", "stalled pushed flags", rd16(16'h07FE), 16'h0201);
    chk("R11", "stalled pushed ip", rd16(16'h07FA), 16'h0BEE);
    t_iret(16'h0BEE, 16'hFFFF, 16'h0201, 16'h0800);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    boundary = 0; fault = 0; iret = 0; halt = 0; nmi = 0; intr = 0; flags_we = 0;
    ip_next = 0; flags_wdata = 0; fault_type = 0; ack_byte = 0;
    tb_we = 0; tb_addr = 0; tb_data = 0; stall_en = 0; stall_q = 0;
    inta_cyc = 0; inta_rise = 0; inta_prev = 0; n_chk = 0; n_fail = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fault_entry();
    t_iret(16'h1234, 16'hFFFF, 16'h02C5, 16'h0800);
    t_int36();
    t_priority();
    t_intr();
    t_step();
    t_halt();
    t_wait_states();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule